// File: doc/BRIEF.md
# Ball-Strike Count Tracker

This block keeps the pitch count for one batter and drives two groups of indicator LEDs. It runs on one system clock. Three push-button levels come in: strike, ball and hit. Each level passes through a short synchroniser and a rising-edge detector, so one press yields exactly one single-cycle event however long the button is held.

Both counts live in one state machine, so a single event can clear both groups together. This happens on a walk (a fourth ball), a strikeout (a third strike) or a hit. Each display is a thermometer code: the number of lit LEDs is the count.

When several presses land in the same cycle, only the most important one is applied. A synchronous reset clears both displays. A button that is still held when reset is released is not counted.

Top module: `pitch_count_tracker`

## Requirements
- R1: While `rst` is high at a rising clock edge, both displays are all zero after that edge.
- R2: Successive strikes step `strike_leds` through 00, 01, 11 (bit 0 lights first).
- R3: Successive balls step `ball_leds` through 000, 001, 011, 111 (bit 0 lights first, then bit 1, then bit 2).
- R4: A ball applied while `ball_leds` is 111 clears both displays to zero.
- R5: A strike applied while `strike_leds` is 11 clears both displays to zero.
- R6: A hit clears both displays to zero.
- R7: When presses arrive in the same cycle, only one event is applied, chosen in the order hit, then ball, then strike.
- R8: A held button counts once. A press is sampled on the first clock edge at which the button is high, and the display changes on the third rising edge counted from that one.
- R9: A button held high through the release of reset produces no count.
- R10: Each display shows only thermometer codes and changes only in response to an applied event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strike_btn | input | 1 | Strike button level, asynchronous |
| ball_btn | input | 1 | Ball button level, asynchronous |
| hit_btn | input | 1 | Hit button level, asynchronous |
| strike_leds | output | STRIKE_W | Strike display, thermometer code |
| ball_leds | output | BALL_W | Ball display, thermometer code |

## Verification
The bench targets the wrap points: the fourth ball and the third strike must both clear the other display as well. A design that resets only its own group would leave stale LEDs lit. Simultaneous presses check the priority order; a design that applied every pulse, or used the wrong order, would show combined or misordered counts. Long holds and a button held across reset release check the edge detector; a level-sensitive or cleared-history detector would count a press twice or invent one. A directed press checks the exact latency, which would slip if a register were added or dropped.

// File: rtl/pitch_pkg.sv
package pitch_pkg;

  localparam int unsigned MAX_W = 8;

  typedef logic [MAX_W-1:0] therm_t;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_STRIKE = 2'd1,
    EV_BALL   = 2'd2,
    EV_HIT    = 2'd3
  } evt_e;

  // Legal thermometer: all ones in the low bits, zeros above.
  function automatic logic therm_legal(input therm_t code);
    therm_t inc;
    inc = code + therm_t'(1);
    return (code & inc) == '0;
  endfunction

  // True when every one of the w display bits is lit.
  function automatic logic therm_full(input therm_t code, input int unsigned w);
    therm_t all_lit;
    all_lit = '0;
    for (int i = 0; i < int'(MAX_W); i++) begin
      if (i < int'(w)) all_lit[i] = 1'b1;
    end
    return code == all_lit;
  endfunction

  // Light one more LED above the lit ones.
  function automatic therm_t therm_step(input therm_t code);
    return {code[MAX_W-2:0], 1'b1};
  endfunction

endpackage

// File: rtl/press_detect.sv
module press_detect #(
  parameter int unsigned N_BTN       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_BTN-1:0] btn_raw,
  output logic [N_BTN-1:0] press
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][N_BTN-1:0] sync_q;
  logic [N_BTN-1:0]                  prev_q;

  // Reset presets the chain to "pressed" so that a held button is not seen
  // as a new press once reset is released.
  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= '1;
    else     sync_q[0] <= btn_raw;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) sync_q[s] <= '1;
      else     sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= sync_q[LAST];
  end

  assign press = sync_q[LAST] & ~prev_q;
endmodule

// File: rtl/event_select.sv
module event_select
  import pitch_pkg::*;
(
  input  logic strike_evt,
  input  logic ball_evt,
  input  logic hit_evt,
  output evt_e applied
);
  always_comb begin
    if (hit_evt)         applied = EV_HIT;
    else if (ball_evt)   applied = EV_BALL;
    else if (strike_evt) applied = EV_STRIKE;
    else                 applied = EV_NONE;
  end
endmodule

// File: rtl/count_fsm.sv
module count_fsm
  import pitch_pkg::*;
#(
  parameter int unsigned STRIKE_W = 2,
  parameter int unsigned BALL_W   = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  evt_e                evt,
  output logic [STRIKE_W-1:0] strike_disp,
  output logic [BALL_W-1:0]   ball_disp
);
  logic [STRIKE_W-1:0] strike_q, strike_d;
  logic [BALL_W-1:0]   ball_q, ball_d;
  therm_t              s_ext, b_ext, s_step, b_step;

  assign s_ext  = therm_t'(strike_q);
  assign b_ext  = therm_t'(ball_q);
  assign s_step = therm_step(s_ext);
  assign b_step = therm_step(b_ext);

  always_comb begin
    strike_d = strike_q;
    ball_d   = ball_q;
    unique case (evt)
      EV_HIT: begin
        strike_d = '0;
        ball_d   = '0;
      end
      EV_BALL: begin
        if (!therm_legal(b_ext)) begin
          ball_d = '0;
        end else if (therm_full(b_ext, BALL_W)) begin
          strike_d = '0;
          ball_d   = '0;
        end else begin
          ball_d = b_step[BALL_W-1:0];
        end
      end
      EV_STRIKE: begin
        if (!therm_legal(s_ext)) begin
          strike_d = '0;
        end else if (therm_full(s_ext, STRIKE_W)) begin
          strike_d = '0;
          ball_d   = '0;
        end else begin
          strike_d = s_step[STRIKE_W-1:0];
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strike_q <= '0;
      ball_q   <= '0;
    end else begin
      strike_q <= strike_d;
      ball_q   <= ball_d;
    end
  end

  assign strike_disp = strike_q;
  assign ball_disp   = ball_q;
endmodule

// File: rtl/pitch_count_tracker.sv
module pitch_count_tracker
  import pitch_pkg::*;
#(
  parameter int unsigned STRIKE_W    = 2,
  parameter int unsigned BALL_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                strike_btn,
  input  logic                ball_btn,
  input  logic                hit_btn,
  output logic [STRIKE_W-1:0] strike_leds,
  output logic [BALL_W-1:0]   ball_leds
);
  localparam int unsigned N_BTN = 3;

  logic [N_BTN-1:0] press;
  logic             strike_evt, ball_evt, hit_evt;
  evt_e             applied_evt;

  press_detect #(
    .N_BTN      (N_BTN),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_press (
    .clk    (clk),
    .rst    (rst),
    .btn_raw({hit_btn, ball_btn, strike_btn}),
    .press  (press)
  );

  assign strike_evt = press[0];
  assign ball_evt   = press[1];
  assign hit_evt    = press[2];

  event_select u_sel (
    .strike_evt(strike_evt),
    .ball_evt  (ball_evt),
    .hit_evt   (hit_evt),
    .applied   (applied_evt)
  );

  count_fsm #(
    .STRIKE_W(STRIKE_W),
    .BALL_W  (BALL_W)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .evt        (applied_evt),
    .strike_disp(strike_leds),
    .ball_disp  (ball_leds)
  );
endmodule

// File: rtl/pitch_count_chk.sv
module pitch_count_chk
  import pitch_pkg::*;
#(
  parameter int unsigned STRIKE_W = 2,
  parameter int unsigned BALL_W   = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                strike_evt,
  input logic                ball_evt,
  input logic                hit_evt,
  input evt_e                applied_evt,
  input logic [STRIKE_W-1:0] strike_leds,
  input logic [BALL_W-1:0]   ball_leds
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (strike_leds == '0 && ball_leds == '0));

  // R10
  therm_code_chk: assert property (@(posedge clk) disable iff (rst)
    therm_legal(therm_t'(strike_leds)) && therm_legal(therm_t'(ball_leds)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (applied_evt == EV_NONE) |=> ($stable(strike_leds) && $stable(ball_leds)));

  // R6
  hit_clear_chk: assert property (@(posedge clk) disable iff (rst)
    hit_evt |=> (strike_leds == '0 && ball_leds == '0));

  // R4
  walk_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ball_evt && !hit_evt && therm_full(therm_t'(ball_leds), BALL_W))
      |=> (strike_leds == '0 && ball_leds == '0));

  // R5
  strikeout_chk: assert property (@(posedge clk) disable iff (rst)
    (strike_evt && !ball_evt && !hit_evt && therm_full(therm_t'(strike_leds), STRIKE_W))
      |=> (strike_leds == '0 && ball_leds == '0));

  // R7
  prio_ball_chk: assert property (@(posedge clk) disable iff (rst)
    (ball_evt && !hit_evt) |-> applied_evt == EV_BALL);

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    strike_evt |=> !strike_evt);
endmodule

bind pitch_count_tracker pitch_count_chk #(
  .STRIKE_W(STRIKE_W),
  .BALL_W  (BALL_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .strike_evt (strike_evt),
  .ball_evt   (ball_evt),
  .hit_evt    (hit_evt),
  .applied_evt(applied_evt),
  .strike_leds(strike_leds),
  .ball_leds  (ball_leds)
);

// File: tb/tb_pitch_count_tracker.sv
module tb_pitch_count_tracker;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strike_btn = 1'b0, ball_btn = 1'b0, hit_btn = 1'b0;
  logic [1:0] strike_leds;
  logic [2:0] ball_leds;

  int n_checks = 0;
  int n_errors = 0;
  int m_str = 0;
  int m_bal = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pitch_count_tracker dut (
    .clk(clk), .rst(rst),
    .strike_btn(strike_btn), .ball_btn(ball_btn), .hit_btn(hit_btn),
    .strike_leds(strike_leds), .ball_leds(ball_leds)
  );

  function automatic logic [3:0] lit(input int n);
    return 4'((1 << n) - 1);
  endfunction

  // Model: mask bit2=hit, bit1=ball, bit0=strike.
  function automatic void model(input logic [2:0] m);
    if (m[2]) begin
      m_str = 0; m_bal = 0;
    end else if (m[1]) begin
      if (m_bal == 3) begin m_str = 0; m_bal = 0; end
      else m_bal++;
    end else if (m[0]) begin
      if (m_str == 2) begin m_str = 0; m_bal = 0; end
      else m_str++;
    end
  endfunction

  task automatic check(input string req);
    logic [1:0] es;
    logic [2:0] eb;
    es = 2'(lit(m_str));
    eb = 3'(lit(m_bal));
    n_checks++;
    if (strike_leds !== es || ball_leds !== eb) begin
      n_errors++;
      $display("FAIL %s: actual strike=%b ball=%b expected strike=%b ball=%b",
               req, strike_leds, ball_leds, es, eb);
    end
  endtask

  task automatic press(input logic [2:0] m, input int hold, input string req);
    @(negedge clk);
    {hit_btn, ball_btn, strike_btn} = m;
    repeat (hold) @(negedge clk);
    {hit_btn, ball_btn, strike_btn} = 3'b000;
    repeat (4) @(negedge clk);
    model(m);
    check(req);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); m_str = 0; m_bal = 0;
    check("R1");
    rst = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1");
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R2 / R5: strikes step then third strike clears both
    press(3'b010, 1, "R3");
    press(3'b001, 1, "R2");
    press(3'b001, 1, "R2");
    press(3'b001, 2, "R5");

    // R3 / R4: balls to 111 then walk clears both
    press(3'b001, 1, "R2");
    press(3'b010, 1, "R3");
    press(3'b010, 1, "R3");
    press(3'b010, 1, "R3");
    press(3'b010, 3, "R4");

    // R6: hit from a mixed count
    press(3'b001, 1, "R2");
    press(3'b010, 1, "R3");
    press(3'b100, 1, "R6");

    // R7: simultaneous presses
    press(3'b011, 1, "R7");
    press(3'b111, 1, "R7");
    press(3'b001, 1, "R7");
    press(3'b011, 1, "R7");

    // R8: long hold counts once; exact latency
    press(3'b001, 20, "R8");
    press(3'b100, 1, "R6");
    @(negedge clk); strike_btn = 1'b1;
    @(negedge clk);
    @(negedge clk); check("R8");
    @(negedge clk); model(3'b001); check("R8");
    strike_btn = 1'b0;
    repeat (4) @(negedge clk);

    // R1: reset from a nonzero count
    press(3'b010, 1, "R3");
    do_reset();

    // R9: button held across reset release
    @(negedge clk); ball_btn = 1'b1; rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    repeat (8) @(negedge clk);
    check("R9");
    ball_btn = 1'b0;
    repeat (4) @(negedge clk);
    press(3'b010, 1, "R9");

    // R10 plus all: constrained random
    for (int i = 0; i < 300; i++) begin
      logic [2:0] m;
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 45)      m = 3'b001;
      else if (r < 85) m = 3'b010;
      else if (r < 93) m = 3'b100;
      else             m = 3'($urandom_range(1, 7));
      press(m, int'($urandom_range(1, 6)), "R10");
      if ($urandom_range(0, 49) == 0) do_reset();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule